// File: doc/BRIEF.md
# System management interrupt source mapper

This block watches sixteen interrupt request lines and turns selected ones into a single system management interrupt request. Seven sources are watched. Four belong to peripheral functions: parallel, serial B, serial A and floppy. Each of these follows whatever line its programmable IRQ number selects, so reprogramming a number moves the source to another line. The other three are tied to the fixed lines 12, 1 and 10.

Two enable registers arm the sources one by one. Two status registers record which armed sources have seen a rising edge. Each status register also holds a few plain storage bits that software can write freely. The request output stays high while any armed source has its status bit set. Software clears a status bit by writing a one to it.

Register access uses a valid/ready request channel and a valid/ready read response channel. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is waiting, or when the waiting response is being taken in the same cycle. A read fills the one-entry response slot on the edge where it is taken. The response stays in the slot, unchanged, until `rsp_ready` is high. Writes produce no response.

Top module: `smi_event_mapper`

## Requirements
- R1: After reset, both enable registers and both status registers read zero, `smi_o` is low and `rsp_valid` is low.
- R2: `req_addr` selects a register: 0 is the device enables, 1 is the fixed-line enables, 2 is the device status and 3 is the fixed-line status. Each enable register stores all 8 written bits and returns them on a read. An enable register changes only when a write to it is taken.
- R3: Device sources use the enable bits parallel=1, serial B=2, serial A=3 and floppy=4. They use the same bit positions in the device status register. Each device source follows `irq_lines[n]`, where n is that device's IRQ number input.
- R4: The fixed sources are line 12, line 1 and line 10. Their enable bits are 0, 1 and 7, and their status bits in the fixed-line status register are 0, 1 and 4.
- R5: A status bit is set on a clock edge where its source's level is high and was low at the previous edge, and only if the source was enabled before that edge. Enabling a source whose line is already high sets nothing. Moving a device IRQ number onto a line that is already high counts as a rising edge. A status bit stays set after its line falls.
- R6: A write to a status register clears each status bit written with a one. Storage bits are loaded directly from the written data: mask 0xE1 in the device status register and mask 0xEC in the fixed-line status register. If a new edge and a clear hit the same bit on the same edge, the bit ends up set.
- R7: `smi_o` is high in exactly those cycles where some source has both its status bit and its enable bit set. It goes high in the cycle after the edge that latches the status.
- R8: A read returns the register value as it was before the edge on which the read is taken. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold, and `req_ready` is low.
- R9: A taken write never raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Interrupt request line levels |
| par_irq_num | input | 4 | Line number followed by the parallel source |
| ser_b_irq_num | input | 4 | Line number followed by the serial B source |
| ser_a_irq_num | input | 4 | Line number followed by the serial A source |
| fdc_irq_num | input | 4 | Line number followed by the floppy source |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Register request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Read response taken |
| rsp_rdata | output | 8 | Read data |
| smi_o | output | 1 | System management interrupt request |

## Verification
Three events are hard to produce from the ports: a status clear and a fresh edge landing on the same clock edge, a device number being moved onto a line that is already high, and an enable being set while its line is high. Directed sequences line each of these up cycle by cycle. After that, a long seeded random phase toggles lines, remaps device numbers and stalls `rsp_ready`. Every output in that phase is checked against a bench model built from the requirements.

// File: rtl/smi_map_pkg.sv
package smi_map_pkg;
  localparam int REG_W = 8;
  localparam int N_DEV = 4;
  localparam int N_FIX = 3;
  localparam int N_SRC = N_DEV + N_FIX;

  typedef enum logic [1:0] {
    SEL_EN_DEV = 2'd0,
    SEL_EN_FIX = 2'd1,
    SEL_ST_DEV = 2'd2,
    SEL_ST_FIX = 2'd3
  } reg_sel_e;

  // bits of each status register that are plain storage
  localparam logic [REG_W-1:0] DEV_KEEP_MASK = 8'hE1;
  localparam logic [REG_W-1:0] FIX_KEEP_MASK = 8'hEC;

  // source order: parallel, serial B, serial A, floppy, fixed A, fixed B, fixed C
  localparam int EN_POS [N_SRC] = '{1, 2, 3, 4, 0, 1, 7};
  localparam int ST_POS [N_SRC] = '{1, 2, 3, 4, 0, 1, 4};
endpackage

// File: rtl/smi_src_select.sv
module smi_src_select #(
  parameter int N_IRQ = 16,
  parameter int IRQW  = $clog2(N_IRQ),
  parameter int N_SRC = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_IRQ-1:0]           irq_lines,
  input  logic [N_SRC-1:0][IRQW-1:0] src_num,
  output logic [N_SRC-1:0]           src_rise
);
  logic [N_SRC-1:0] lvl;
  logic [N_SRC-1:0] lvl_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign lvl[g]      = irq_lines[src_num[g]];
    assign src_rise[g] = lvl[g] & ~lvl_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end
endmodule

// File: rtl/smi_status_regs.sv
module smi_status_regs
  import smi_map_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [N_SRC-1:0] src_rise,
  output logic [REG_W-1:0] en_dev,
  output logic [REG_W-1:0] en_fix,
  output logic [REG_W-1:0] st_dev,
  output logic [REG_W-1:0] st_fix
);
  logic [REG_W-1:0] set_dev, set_fix;
  logic [REG_W-1:0] nxt_dev, nxt_fix;

  always_comb begin
    set_dev = '0;
    set_fix = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (s < N_DEV) begin
        if (src_rise[s] && en_dev[EN_POS[s]]) set_dev[ST_POS[s]] = 1'b1;
      end else begin
        if (src_rise[s] && en_fix[EN_POS[s]]) set_fix[ST_POS[s]] = 1'b1;
      end
    end
  end

  always_comb begin
    nxt_dev = st_dev;
    nxt_fix = st_fix;
    if (wr_en && wr_sel == SEL_ST_DEV)
      nxt_dev = (wr_data & DEV_KEEP_MASK) | (st_dev & ~DEV_KEEP_MASK & ~wr_data);
    if (wr_en && wr_sel == SEL_ST_FIX)
      nxt_fix = (wr_data & FIX_KEEP_MASK) | (st_fix & ~FIX_KEEP_MASK & ~wr_data);
    nxt_dev = nxt_dev | set_dev;
    nxt_fix = nxt_fix | set_fix;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_dev <= '0;
      en_fix <= '0;
      st_dev <= '0;
      st_fix <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_EN_DEV) en_dev <= wr_data;
      if (wr_en && wr_sel == SEL_EN_FIX) en_fix <= wr_data;
      st_dev <= nxt_dev;
      st_fix <= nxt_fix;
    end
  end
endmodule

// File: rtl/smi_rsp_stage.sv
module smi_rsp_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] rd_value,
  output logic          req_ready,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata
);
  logic take_rd;

  assign req_ready = ~rsp_valid | rsp_ready;
  assign take_rd   = req_valid & req_ready & ~req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (take_rd) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/smi_event_mapper.sv
module smi_event_mapper
  import smi_map_pkg::*;
#(
  parameter int N_IRQ     = 16,
  parameter int IRQW      = $clog2(N_IRQ),
  parameter int FIX_IRQ_A = 12,
  parameter int FIX_IRQ_B = 1,
  parameter int FIX_IRQ_C = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_lines,
  input  logic [IRQW-1:0]  par_irq_num,
  input  logic [IRQW-1:0]  ser_b_irq_num,
  input  logic [IRQW-1:0]  ser_a_irq_num,
  input  logic [IRQW-1:0]  fdc_irq_num,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_addr,
  input  logic [REG_W-1:0] req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [REG_W-1:0] rsp_rdata,
  output logic             smi_o
);
  logic [N_SRC-1:0][IRQW-1:0] src_num;
  logic [N_SRC-1:0]           src_rise;
  logic [REG_W-1:0]           en_dev, en_fix, st_dev, st_fix;
  logic [REG_W-1:0]           rd_value;
  logic                       wr_en;
  logic [N_SRC-1:0]           armed;

  always_comb begin
    src_num[0] = par_irq_num;
    src_num[1] = ser_b_irq_num;
    src_num[2] = ser_a_irq_num;
    src_num[3] = fdc_irq_num;
    src_num[4] = IRQW'(FIX_IRQ_A);
    src_num[5] = IRQW'(FIX_IRQ_B);
    src_num[6] = IRQW'(FIX_IRQ_C);
  end

  smi_src_select #(.N_IRQ(N_IRQ), .IRQW(IRQW), .N_SRC(N_SRC)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_lines(irq_lines),
    .src_num  (src_num),
    .src_rise (src_rise)
  );

  assign wr_en = req_valid & req_ready & req_write;

  smi_status_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (req_addr),
    .wr_data (req_wdata),
    .src_rise(src_rise),
    .en_dev  (en_dev),
    .en_fix  (en_fix),
    .st_dev  (st_dev),
    .st_fix  (st_fix)
  );

  always_comb begin
    unique case (req_addr)
      SEL_EN_DEV: rd_value = en_dev;
      SEL_EN_FIX: rd_value = en_fix;
      SEL_ST_DEV: rd_value = st_dev;
      default:    rd_value = st_fix;
    endcase
  end

  smi_rsp_stage #(.DW(REG_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .rd_value (rd_value),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_arm
    if (g < N_DEV) begin : g_dev
      assign armed[g] = st_dev[ST_POS[g]] & en_dev[EN_POS[g]];
    end else begin : g_fix
      assign armed[g] = st_fix[ST_POS[g]] & en_fix[EN_POS[g]];
    end
  end

  assign smi_o = |armed;
endmodule

// File: rtl/smi_event_mapper_chk.sv
module smi_event_mapper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic [1:0] req_addr,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_rdata,
  input logic       smi_o,
  input logic [7:0] en_dev,
  input logic [7:0] en_fix,
  input logic [7:0] st_dev,
  input logic [7:0] st_fix
);
  logic wr_take;
  assign wr_take = req_valid & req_ready & req_write;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R8

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take && (!rsp_valid || rsp_ready) |=> !rsp_valid); // R9

  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_dev == 8'h00 && en_fix == 8'h00) |-> !smi_o); // R7

  AST_EN_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_dev) |-> $past(wr_take && req_addr == 2'd0)); // R2

  AST_DEV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    |($past(st_dev) & ~st_dev & 8'h1E) |-> $past(wr_take && req_addr == 2'd2)); // R6

  AST_FIX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    |($past(st_fix) & ~st_fix & 8'h13) |-> $past(wr_take && req_addr == 2'd3)); // R6
endmodule

bind smi_event_mapper smi_event_mapper_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata),
  .smi_o    (smi_o),
  .en_dev   (en_dev),
  .en_fix   (en_fix),
  .st_dev   (st_dev),
  .st_fix   (st_fix)
);

// File: tb/tb_smi_event_mapper.sv
module tb_smi_event_mapper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic [3:0] par_n = 4'd7, serb_n = 4'd3, sera_n = 4'd4, fdc_n = 4'd6;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, smi_o;
  logic [7:0] rsp_rdata;

  always #5 clk = ~clk;

  smi_event_mapper dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .par_irq_num(par_n), .ser_b_irq_num(serb_n), .ser_a_irq_num(sera_n),
    .fdc_irq_num(fdc_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .smi_o(smi_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  // model state
  logic [7:0] m_en_a, m_en_b, m_st_a, m_st_b, m_rsp_d;
  logic [6:0] m_prev;
  logic m_rsp_v;

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  function automatic logic [3:0] num_of(input int s);
    case (s)
      0: return par_n;
      1: return serb_n;
      2: return sera_n;
      3: return fdc_n;
      4: return 4'd12;
      5: return 4'd1;
      default: return 4'd10;
    endcase
  endfunction

  function automatic int en_bit(input int s);
    case (s) 0: return 1; 1: return 2; 2: return 3; 3: return 4;
             4: return 0; 5: return 1; default: return 7; endcase
  endfunction

  function automatic int st_bit(input int s);
    case (s) 0: return 1; 1: return 2; 2: return 3; 3: return 4;
             4: return 0; 5: return 1; default: return 4; endcase
  endfunction

  function automatic logic exp_smi();
    logic r = 1'b0;
    for (int s = 0; s < 7; s++)
      if (s < 4) r |= m_st_a[st_bit(s)] & m_en_a[en_bit(s)];
      else       r |= m_st_b[st_bit(s)] & m_en_b[en_bit(s)];
    return r;
  endfunction

  function automatic logic [7:0] reg_val(input logic [1:0] a);
    case (a) 2'd0: return m_en_a; 2'd1: return m_en_b;
             2'd2: return m_st_a; default: return m_st_b; endcase
  endfunction

  task automatic model_reset();
    m_en_a = 0; m_en_b = 0; m_st_a = 0; m_st_b = 0;
    m_prev = 0; m_rsp_v = 0; m_rsp_d = 0;
  endtask

  // one clock: inputs are already driven
  task automatic cyc();
    logic [6:0] lvl;
    logic [7:0] n_en_a, n_en_b, n_st_a, n_st_b, set_a, set_b, n_rsp_d;
    logic acc, n_rsp_v;
    #1;
    chk(req_ready == (!m_rsp_v || rsp_ready), "R8 req_ready", req_ready, !m_rsp_v || rsp_ready);
    for (int s = 0; s < 7; s++) lvl[s] = irq_lines[num_of(s)];
    set_a = 0; set_b = 0;
    for (int s = 0; s < 7; s++)
      if (lvl[s] && !m_prev[s]) begin
        if (s < 4) begin if (m_en_a[en_bit(s)]) set_a[st_bit(s)] = 1; end
        else       begin if (m_en_b[en_bit(s)]) set_b[st_bit(s)] = 1; end
      end
    acc = req_valid && (!m_rsp_v || rsp_ready);
    n_en_a = m_en_a; n_en_b = m_en_b; n_st_a = m_st_a; n_st_b = m_st_b;
    if (acc && req_write) begin
      case (req_addr)
        2'd0: n_en_a = req_wdata;
        2'd1: n_en_b = req_wdata;
        2'd2: n_st_a = (req_wdata & 8'hE1) | (m_st_a & 8'h1E & ~req_wdata);
        default: n_st_b = (req_wdata & 8'hEC) | (m_st_b & 8'h13 & ~req_wdata);
      endcase
    end
    n_st_a |= set_a; n_st_b |= set_b;
    n_rsp_v = m_rsp_v; n_rsp_d = m_rsp_d;
    if (acc && !req_write) begin n_rsp_v = 1; n_rsp_d = reg_val(req_addr); end
    else if (rsp_ready) n_rsp_v = 0;
    @(posedge clk);
    m_en_a = n_en_a; m_en_b = n_en_b; m_st_a = n_st_a; m_st_b = n_st_b;
    m_prev = lvl; m_rsp_v = n_rsp_v; m_rsp_d = n_rsp_d;
    @(negedge clk);
    chk(smi_o == exp_smi(), {tag, " R7 smi_o"}, smi_o, exp_smi());
    chk(rsp_valid == m_rsp_v, {tag, " R8 rsp_valid"}, rsp_valid, m_rsp_v);
    if (m_rsp_v) chk(rsp_rdata == m_rsp_d, {tag, " rsp_rdata"}, rsp_rdata, m_rsp_d);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    cyc();
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    cyc();
    req_valid = 0;
    d = rsp_rdata;
    cyc();
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [7:0] e, input string t);
    logic [7:0] d;
    rd(a, d);
    chk(d == e, t, d, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    model_reset();
    irq_lines = 16'h0400;  // high line during reset
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    tag = "R1";
    chk(smi_o == 0, "R1 smi after reset", smi_o, 0);
    chk(rsp_valid == 0, "R1 rsp_valid after reset", rsp_valid, 0);
    for (int a = 0; a < 4; a++) rd_expect(2'(a), 8'h00, "R1 register zero");
    irq_lines = 0; cyc();

    // R2 enable read back
    tag = "R2";
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
    rd_expect(2'd0, 8'hA5, "R2 device enable readback");
    rd_expect(2'd1, 8'h3C, "R2 fixed enable readback");
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);

    // R3 parallel on line 7, enable bit 1
    tag = "R3";
    wr(2'd0, 8'h02);
    irq_lines[7] = 1; cyc();
    chk(smi_o == 1, "R3 parallel source smi", smi_o, 1);
    rd_expect(2'd2, 8'h02, "R3 parallel status bit1");
    irq_lines[7] = 0; cyc();
    chk(smi_o == 1, "R5 status sticky after line falls", smi_o, 1);
    wr(2'd2, 8'h02);
    chk(smi_o == 0, "R6 W1C clears smi", smi_o, 0);
    // serial A on line 4 while only floppy enabled: no latch
    wr(2'd0, 8'h10);
    irq_lines[4] = 1; cyc();
    rd_expect(2'd2, 8'h00, "R3 disabled serial A ignored");
    irq_lines[6] = 1; cyc();
    rd_expect(2'd2, 8'h10, "R3 floppy status bit4");
    irq_lines = 0; wr(2'd2, 8'hFF); wr(2'd2, 8'h00);
    rd_expect(2'd2, 8'h00, "R6 storage bits written back to zero");

    // R4 fixed lines
    tag = "R4";
    wr(2'd1, 8'h83);
    irq_lines[10] = 1; cyc();
    rd_expect(2'd3, 8'h10, "R4 line10 status bit4");
    irq_lines[12] = 1; irq_lines[1] = 1; cyc();
    rd_expect(2'd3, 8'h13, "R4 lines 12 and 1 status bits 0,1");
    irq_lines = 0; wr(2'd3, 8'h13);
    chk(smi_o == 0, "R4 fixed cleared", smi_o, 0);

    // R5 enable while high: no latch
    tag = "R5";
    wr(2'd1, 8'h00);
    irq_lines[12] = 1; cyc();
    wr(2'd1, 8'h01); cyc();
    rd_expect(2'd3, 8'h00, "R5 enable while high sets nothing");
    // remap serial B onto high line 12
    wr(2'd0, 8'h04); serb_n = 4'd3; cyc();
    serb_n = 4'd12; cyc();
    rd_expect(2'd2, 8'h04, "R5 remap onto high line latches");
    serb_n = 4'd3; irq_lines = 0; wr(2'd2, 8'h04);

    // R6 storage bits and simultaneous set/clear
    tag = "R6";
    wr(2'd2, 8'hFF);
    rd_expect(2'd2, 8'hE1, "R6 device storage mask");
    wr(2'd3, 8'hFF);
    rd_expect(2'd3, 8'hEC, "R6 fixed storage mask");
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    wr(2'd0, 8'h02); irq_lines[7] = 1; cyc();
    irq_lines[7] = 0; cyc();
    irq_lines[7] = 1;
    wr(2'd2, 8'h02);  // clear and new edge on same edge
    rd_expect(2'd2, 8'h02, "R6 set wins over clear");
    irq_lines = 0; wr(2'd2, 8'h02);

    // R8 back-pressure
    tag = "R8";
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = 2'd0; cyc();
    req_addr = 2'd1;
    for (int i = 0; i < 4; i++) cyc();
    chk(rsp_rdata == 8'h02, "R8 held data", rsp_rdata, 8'h02);
    rsp_ready = 1; req_valid = 0; cyc();
    // R9 write with no response
    tag = "R9";
    wr(2'd1, 8'h00);
    chk(rsp_valid == 0, "R9 write gives no response", rsp_valid, 0);

    // random phase
    tag = "R3 R4 R5 R6 rnd";
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 3) == 0) irq_lines[$urandom % 16] ^= 1'b1;
      if (($urandom % 40) == 0) begin
        case ($urandom % 4)
          0: par_n = 4'($urandom); 1: serb_n = 4'($urandom);
          2: sera_n = 4'($urandom); default: fdc_n = 4'($urandom);
        endcase
      end
      req_valid = (($urandom % 4) == 0);
      req_write = (($urandom % 2) == 0);
      req_addr  = 2'($urandom);
      req_wdata = ((req_addr == 2'd2 || req_addr == 2'd3) && ($urandom % 2)) ? 8'h00 : 8'($urandom);
      rsp_ready = (($urandom % 4) != 0);
      cyc();
    end
    req_valid = 0; rsp_ready = 1; cyc();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule